// File: doc/BRIEF.md
# External Bus Cycle Phase Sequencer

This block times a single access on an external memory bus. The access is a chain of up to six phases, A to F, and each phase has its own programmed length. A start strobe, sampled while the sequencer is idle, captures four things: a read/write flag, a 15-bit timing word and a 6-bit function word for the selected window, and the access kind. From the captured values the block produces an address-latch strobe, a chip select, a read strobe and a write strobe. When the last phase ends it raises a one-clock done pulse.

Phase A is the address setup. Phase B holds the address-latch pulse on multiplexed buses. Phases C and D are delay and strobe lead-in. Phase E is the access itself, and it can be stretched by an external READY line, which is taken either straight or through a two-flop synchronizer. Phase F is the hold time after the access, and reads and writes each have their own length for it. A phase programmed to zero clocks is skipped and costs no idle cycle.

Top module: `bus_phase_seq`

## Requirements
- R1: While reset is low, and after reset with no start given, every strobe output and done are 0.
- R2: Phase A lasts timing[1:0] clocks (0..3). No output is active during phase A.
- R3: Phase B lasts 1 clock when timing[2]=0 and 2 clocks when timing[2]=1. Chip select becomes active in phase B. The address-latch strobe is active for all of phase B when func[4]=1 (multiplexed), and is never active when func[4]=0 (demultiplexed). func[5] (bus width) does not affect these outputs.
- R4: Phase C lasts timing[4:3] clocks (0..3) and phase D lasts timing[5] clocks (0..1). The read or write strobe is active during phases D and E.
- R5: Phase E lasts timing[10:6]+1 clocks (1..32) when READY extension is off.
- R6: Phase F lasts timing[12:11] clocks on a read and timing[14:13] clocks on a write. Chip select stays active from phase B to the end of phase F.
- R7: A phase of length zero takes no cycle. Done is high for exactly one clock: the cycle after the last phase ends, A+B+C+D+E+F+1 clocks after the start edge.
- R8: When func[1]=0, READY is ignored. The access length is the same whatever level READY has.
- R9: When func[1]=1 and func[2]=1 (synchronous), phase E is held at its last clock until READY is seen high on a clock edge. Done follows one clock after READY rises.
- R10: When func[1]=1 and func[2]=0 (asynchronous), READY passes through two flops before the sequencer samples it. Done follows three clocks after READY rises.
- R11: A start while an access is in progress is ignored. Timing, function and direction are captured at the accepted start.
- R12: wr_i=0 gives a read and drives only the read strobe. wr_i=1 gives a write and drives only the write strobe. The two strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start one access (sampled when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| timing_i | input | 15 | Phase length word of the selected window |
| func_i | input | 6 | Function word: [1] READY enable, [2] READY synchronous, [4] multiplexed, [5] 16-bit |
| ready_i | input | 1 | External READY |
| ale_o | output | 1 | Address-latch strobe |
| cs_o | output | 1 | Chip select |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| done_o | output | 1 | One-clock end-of-access pulse |

## Verification
The assertions check several things on every cycle: the read and write strobes are mutually exclusive, a strobe never appears without chip select, done never lasts two clocks, the phase B counter stays within two clocks, a stalled phase E holds while READY is low, and the captured configuration stays stable during an access. Only the bench scenarios can show the exact phase lengths for each field, the skipping of zero-length phases, the total latency to done, and the one- and three-clock READY response in the two modes. They also show that a start or a READY level with no defined effect leaves the access unchanged.

// File: rtl/bus_phase_pkg.sv
// Shared types and helpers for the bus phase sequencer.
// Assumes the 15-bit timing word layout given in the brief.
package bus_phase_pkg;
    localparam int TIMING_W = 15;
    localparam int FUNC_W   = 6;
    localparam int LEN_W    = 6;
    localparam int CNT_W    = LEN_W - 1;

    typedef enum logic [2:0] {
        PH_IDLE, PH_A, PH_B, PH_C, PH_D, PH_E, PH_F
    } phase_e;

    // Length in clocks of a phase for a given timing word and direction.
    function automatic logic [LEN_W-1:0] phase_len(phase_e p, logic [TIMING_W-1:0] t, logic wr);
        logic [LEN_W-1:0] len;
        case (p)
            PH_A:    len = {4'd0, t[1:0]};
            PH_B:    len = {5'd0, t[2]} + 6'd1;
            PH_C:    len = {4'd0, t[4:3]};
            PH_D:    len = {5'd0, t[5]};
            PH_E:    len = {1'b0, t[10:6]} + 6'd1;
            PH_F:    len = {4'd0, (wr ? t[14:13] : t[12:11])};
            default: len = '0;
        endcase
        return len;
    endfunction

    // Next phase after p, skipping phases of zero length.
    function automatic phase_e next_phase(phase_e p, logic [TIMING_W-1:0] t, logic wr);
        phase_e n;
        case (p)
            PH_IDLE: n = (phase_len(PH_A, t, wr) != 0) ? PH_A : PH_B;
            PH_A:    n = PH_B;
            PH_B:    n = (phase_len(PH_C, t, wr) != 0) ? PH_C :
                         (phase_len(PH_D, t, wr) != 0) ? PH_D : PH_E;
            PH_C:    n = (phase_len(PH_D, t, wr) != 0) ? PH_D : PH_E;
            PH_D:    n = PH_E;
            PH_E:    n = (phase_len(PH_F, t, wr) != 0) ? PH_F : PH_IDLE;
            default: n = PH_IDLE;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/bus_ready_sync.sv
// READY conditioning: a STAGES-deep synchronizer chain for asynchronous
// READY, or the raw input when the captured mode says synchronous.
// Assumes ready_i is glitch-free when the synchronous mode is chosen.
module bus_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic sync_mode_i,
    output logic ready_o
);
    logic [STAGES-1:0] sr_q;

    // Shift READY through the synchronizer flops.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], ready_i};
    end

    // Pick direct or synchronized READY.
    always_comb ready_o = sync_mode_i ? ready_i : sr_q[STAGES-1];
endmodule

// File: rtl/bus_phase_ctrl.sv
// Phase state machine: captures the configuration on start, walks the
// phases A..F with a down-counter, holds phase E for READY, pulses done.
// Assumes the timing and function inputs are valid in the start cycle.
module bus_phase_ctrl
    import bus_phase_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                wr_i,
    input  logic [TIMING_W-1:0] timing_i,
    input  logic [FUNC_W-1:0]   func_i,
    input  logic                ready_s_i,
    output phase_e              phase_o,
    output logic                wr_q_o,
    output logic                mux_q_o,
    output logic                sync_q_o,
    output logic                done_o
);
    phase_e              ph_q, nxt;
    logic [CNT_W-1:0]    cnt_q, nxt_cnt;
    logic [TIMING_W-1:0] t_q, sel_t;
    logic                wr_q, sel_wr, rdy_en_q, mux_q, sync_q, done_q;
    logic [LEN_W-1:0]    nlen;
    logic                stall;
    logic                unused_func_bits;

    assign unused_func_bits = ^{func_i[0], func_i[3], func_i[5]};

    // Next phase and its counter preload, from live inputs when idle.
    always_comb begin
        sel_t   = (ph_q == PH_IDLE) ? timing_i : t_q;
        sel_wr  = (ph_q == PH_IDLE) ? wr_i : wr_q;
        nxt     = next_phase(ph_q, sel_t, sel_wr);
        nlen    = phase_len(nxt, sel_t, sel_wr);
        nxt_cnt = (nxt == PH_IDLE) ? '0 : CNT_W'(nlen - 6'd1);
        stall   = (ph_q == PH_E) && rdy_en_q && !ready_s_i;
    end

    // Sequencer registers and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE; cnt_q <= '0; t_q <= '0; wr_q <= 1'b0;
            rdy_en_q <= 1'b0; mux_q <= 1'b0; sync_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ph_q == PH_IDLE) begin
                if (start_i) begin
                    t_q <= timing_i; wr_q <= wr_i;
                    rdy_en_q <= func_i[1]; sync_q <= func_i[2]; mux_q <= func_i[4];
                    ph_q <= nxt; cnt_q <= nxt_cnt;
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (!stall) begin
                ph_q   <= nxt;
                cnt_q  <= nxt_cnt;
                done_q <= (nxt == PH_IDLE);
            end
        end
    end

    assign phase_o  = ph_q;
    assign wr_q_o   = wr_q;
    assign mux_q_o  = mux_q;
    assign sync_q_o = sync_q;
    assign done_o   = done_q;

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r3_b_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_B) |-> (cnt_q <= 1));
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_E && cnt_q == '0 && rdy_en_q && !ready_s_i) |=> (ph_q == PH_E));
    a_r11_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |-> ($stable(t_q) && $stable(wr_q)));
endmodule

// File: rtl/bus_strobe_gen.sv
// Decodes the current phase into bus strobes.
// Assumes the phase and captured config come from registers (glitch-free).
module bus_strobe_gen
    import bus_phase_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_i,
    input  logic   wr_q_i,
    input  logic   mux_q_i,
    output logic   ale_o,
    output logic   cs_o,
    output logic   rd_o,
    output logic   wr_o
);
    logic strobe;

    // Phase-to-strobe decode.
    always_comb begin
        strobe = (phase_i == PH_D) || (phase_i == PH_E);
        cs_o   = (phase_i != PH_IDLE) && (phase_i != PH_A);
        ale_o  = (phase_i == PH_B) && mux_q_i;
        rd_o   = strobe && !wr_q_i;
        wr_o   = strobe && wr_q_i;
    end

    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o));
    a_r6_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o || wr_o || ale_o) |-> cs_o);
endmodule

// File: rtl/bus_phase_seq.sv
// Top: external bus access phase sequencer.
// Assumes one access at a time; starts while busy are dropped.
module bus_phase_seq
    import bus_phase_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                wr_i,
    input  logic [TIMING_W-1:0] timing_i,
    input  logic [FUNC_W-1:0]   func_i,
    input  logic                ready_i,
    output logic                ale_o,
    output logic                cs_o,
    output logic                rd_o,
    output logic                wr_o,
    output logic                done_o
);
    phase_e ph;
    logic   wr_q, mux_q, sync_q, ready_s;

    bus_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ready_i(ready_i),
        .sync_mode_i(sync_q), .ready_o(ready_s)
    );

    bus_phase_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
        .timing_i(timing_i), .func_i(func_i), .ready_s_i(ready_s),
        .phase_o(ph), .wr_q_o(wr_q), .mux_q_o(mux_q), .sync_q_o(sync_q),
        .done_o(done_o)
    );

    bus_strobe_gen u_strb (
        .clk(clk), .rst_n(rst_n), .phase_i(ph), .wr_q_i(wr_q), .mux_q_i(mux_q),
        .ale_o(ale_o), .cs_o(cs_o), .rd_o(rd_o), .wr_o(wr_o)
    );
endmodule

// File: tb/bus_phase_seq_tb_top.sv
`timescale 1ns/1ps
module bus_phase_seq_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, wr_i = 1'b0, ready_i = 1'b0;
    logic [14:0] timing_i = '0;
    logic [5:0]  func_i = '0;
    logic ale_o, cs_o, rd_o, wr_o, done_o;
    int total = 0, bad = 0;
    int m_lat, m_cs, m_ale, m_rd, m_wr, m_done_after;

    always #2.5 clk = ~clk;

    bus_phase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
        .timing_i(timing_i), .func_i(func_i), .ready_i(ready_i),
        .ale_o(ale_o), .cs_o(cs_o), .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o)
    );

    function automatic logic [14:0] mk(int a, int b, int c, int d, int e, int rf, int wf);
        return {wf[1:0], rf[1:0], e[4:0], d[0], c[1:0], b[0], a[1:0]};
    endfunction

    // {timing, func, wr, ready level}
    localparam logic [22:0] VECS [8] = '{
        {mk(0,0,0,0,0,0,0),  6'b000000, 1'b0, 1'b1},
        {mk(3,1,3,1,31,3,0), 6'b010000, 1'b0, 1'b1},
        {mk(3,1,3,1,31,3,0), 6'b110000, 1'b1, 1'b1},
        {mk(1,0,0,1,4,2,1),  6'b100000, 1'b1, 1'b0},
        {mk(0,1,2,0,0,0,3),  6'b000010, 1'b0, 1'b1},
        {mk(2,0,1,0,7,1,2),  6'b000110, 1'b1, 1'b1},
        {mk(0,0,0,0,2,1,1),  6'b000000, 1'b0, 1'b0},
        {mk(0,1,0,0,0,0,0),  6'b010000, 1'b1, 1'b0}
    };

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One access; poke>0 re-pulses start with another config at that sample.
    task automatic run(logic [14:0] t, logic [5:0] f, logic wr, logic rdy, int poke);
        ready_i = rdy;
        repeat (3) @(negedge clk);
        timing_i = t; func_i = f; wr_i = wr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        m_lat = 0; m_cs = 0; m_ale = 0; m_rd = 0; m_wr = 0;
        for (int k = 1; k <= 300; k++) begin
            if (done_o) begin m_lat = k; break; end
            m_cs += int'(cs_o); m_ale += int'(ale_o); m_rd += int'(rd_o); m_wr += int'(wr_o);
            if (k == poke) begin
                start_i = 1'b1; wr_i = ~wr; timing_i = '0; func_i = 6'b010000;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        @(negedge clk);
        m_done_after = int'(done_o);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({ale_o, cs_o, rd_o, wr_o, done_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle outputs", int'({ale_o, cs_o, rd_o, wr_o, done_o}), 0);

        // Table walk: R2..R8, R12.
        for (int i = 0; i < 8; i++) begin
            logic [14:0] t; logic [5:0] f; logic wr, rdy;
            int a, b, c, d, e, fl, lat;
            {t, f, wr, rdy} = VECS[i];
            a = t[1:0]; b = t[2] + 1; c = t[4:3]; d = t[5]; e = t[10:6] + 1;
            fl = wr ? t[14:13] : t[12:11];
            lat = a + b + c + d + e + fl + 1;
            run(t, f, wr, rdy, 0);
            chk("R7 latency (R2 R5 R8)", m_lat, lat);
            chk("R6 cs cycles", m_cs, lat - 1 - a);
            chk("R3 ale cycles", m_ale, f[4] ? b : 0);
            chk("R4 R12 read strobe", m_rd, wr ? 0 : d + e);
            chk("R4 R12 write strobe", m_wr, wr ? d + e : 0);
            chk("R7 done single", m_done_after, 0);
        end

        // R11: start during a busy access is dropped.
        run(mk(3,1,3,1,31,3,0), 6'b000000, 1'b0, 1'b1, 3);
        chk("R11 latency kept", m_lat, 45);
        chk("R11 no write strobe", m_wr, 0);
        chk("R11 no ale", m_ale, 0);

        // R9: synchronous READY stall, release one clock to done.
        ready_i = 1'b0;
        repeat (3) @(negedge clk);
        timing_i = '0; func_i = 6'b000110; wr_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (19) @(negedge clk);
        chk("R9 stall rd held", int'(rd_o), 1);
        chk("R9 stall no done", int'(done_o), 0);
        ready_i = 1'b1;
        @(negedge clk);
        chk("R9 sync done", int'(done_o), 1);
        chk("R9 strobe off", int'(rd_o), 0);

        // R10: asynchronous READY, three clocks to done.
        ready_i = 1'b0;
        repeat (3) @(negedge clk);
        timing_i = '0; func_i = 6'b000010; wr_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (19) @(negedge clk);
        chk("R10 stall wr held", int'(wr_o), 1);
        ready_i = 1'b1;
        @(negedge clk);
        chk("R10 not yet (1)", int'(done_o), 0);
        @(negedge clk);
        chk("R10 not yet (2)", int'(done_o), 0);
        @(negedge clk);
        chk("R10 async done", int'(done_o), 1);
        @(negedge clk);
        chk("R7 done single after stall", int'(done_o), 0);

        // R8: READY low with extension off still finishes on time.
        run(mk(0,0,0,0,5,0,0), 6'b000100, 1'b0, 1'b0, 0);
        chk("R8 ready ignored", m_lat, 8);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule